// File: doc/BRIEF.md
# Trigger-Driven Sequence Processing Unit

This block sits in front of an instruction dispatcher inside a multi-channel waveform generator. It keeps its own small table of sequence entries, apart from the instruction memory. Each entry has a header with a time delay and a completion action, and a payload with a starting instruction address and an instruction count. A second small table, the trigger map, gives a sequence index for each trigger line. When a trigger arrives, the unit looks up the sequence and captures the entry. It counts down the delay, then presents address and count to the dispatcher with run enable high. When the dispatcher reports done, the unit applies the entry's completion action.

The state machine has four states: IDLE (waits for any trigger), DELAY (counts down the captured delay), RUN (run enable high until done) and HOLD (a parked sequence that waits for a trigger). The transitions are named as follows. *Launch* goes from IDLE to DELAY when a trigger arrives. *Expire* goes from DELAY to RUN when the delay count reaches zero. On done, the action code picks the transition out of RUN. *Restart* and *Advance* go to DELAY, *Park* goes to HOLD and *Retire* goes to IDLE. *Resume* goes from HOLD to DELAY on a trigger. *Abort* goes from any state to IDLE.

Every path takes a fixed number of cycles from the trigger edge, so several units fed the same trigger stay in step.

Top module: `spu_top`

## Requirements
- R1: After reset, state_o is 0 (IDLE), and disp_run_o, busy_o and missed_o are all zero.
- R2: In IDLE, a cycle with any trigger bit high selects the lowest-numbered high line. The trigger map gives that line's sequence index. That entry's start address and count then appear on disp_start_o and disp_count_o, and its index appears on cur_seq_o.
- R3: With a captured delay D, disp_run_o rises D+1 clock edges after the edge that sampled the trigger (or the done pulse). state_o is 1 (DELAY) in between.
- R4: disp_run_o stays high while disp_done_i is low. It is low in the cycle after an edge that samples disp_done_i high.
- R5: Action code 0 (restart) reloads the same sequence and runs it again after its delay.
- R6: Action code 1 (advance) loads sequence index + 1, modulo the table depth, and runs it after its delay.
- R7: Action code 2 (park) enters state_o = 3 (HOLD). The next trigger on any line loads sequence index + 1, and that trigger is not counted as missed.
- R8: Action code 3 (retire) returns to state_o = 0 with busy_o low.
- R9: Every cycle in DELAY or RUN with any trigger bit high adds one to missed_o. The count saturates at its all-ones value.
- R10: abort_i high at an edge forces IDLE. disp_run_o is low in the following cycle.
- R11: An entry is captured when it is loaded. A table write to the running entry does not change disp_start_o during that run, and it takes effect at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | N_TRIG | Trigger lines, active high, sampled each edge |
| abort_i | input | 1 | Forces return to IDLE |
| map_we_i | input | 1 | Trigger map write strobe |
| map_line_i | input | TW | Trigger line to remap |
| map_seq_i | input | SEQ_W | Sequence index for that line |
| tbl_we_i | input | 1 | Sequence table write strobe |
| tbl_idx_i | input | SEQ_W | Entry index to write |
| tbl_start_i | input | ADDR_W | Entry start instruction address |
| tbl_count_i | input | CNT_W | Entry instruction count |
| tbl_delay_i | input | DLY_W | Entry delay in cycles |
| tbl_act_i | input | 2 | Entry completion action code |
| disp_done_i | input | 1 | Dispatcher finished pulse |
| disp_start_o | output | ADDR_W | Start address to dispatcher |
| disp_count_o | output | CNT_W | Instruction count to dispatcher |
| disp_run_o | output | 1 | Run enable to dispatcher |
| busy_o | output | 1 | High in DELAY or RUN |
| state_o | output | 3 | State code: 0 IDLE, 1 DELAY, 2 RUN, 3 HOLD |
| cur_seq_o | output | SEQ_W | Index of the captured sequence |
| missed_o | output | MISS_W | Saturating missed-trigger count |

## Verification
The bench builds the unit with four trigger lines, a four-entry table, a 4-bit delay and a 3-bit missed counter. With four lines, all fifteen nonzero trigger patterns can be swept, so every priority case of the lowest-line rule is covered. With a 4-bit delay, every delay value from 0 to 15 can be swept with arithmetic latency checks. With four entries, the advance action wraps from the last index to index 0. With a 3-bit counter, saturation of the missed count is reached in a few cycles.

// File: rtl/spu_pkg.sv
package spu_pkg;

    typedef enum logic [1:0] {
        ACT_RESTART = 2'd0,
        ACT_ADVANCE = 2'd1,
        ACT_PARK    = 2'd2,
        ACT_RETIRE  = 2'd3
    } end_act_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DELAY = 3'd1,
        ST_RUN   = 3'd2,
        ST_HOLD  = 3'd3
    } spu_state_e;

endpackage

// File: rtl/spu_seq_table.sv
module spu_seq_table #(
    parameter int N_TRIG = 8,
    parameter int SEQ_W  = 4,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 10,
    parameter int DLY_W  = 16,
    localparam int TW    = (N_TRIG > 1) ? $clog2(N_TRIG) : 1,
    localparam int DEPTH = 1 << SEQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_we,
    input  logic [SEQ_W-1:0]  ent_idx,
    input  logic [ADDR_W-1:0] ent_start,
    input  logic [CNT_W-1:0]  ent_count,
    input  logic [DLY_W-1:0]  ent_delay,
    input  logic [1:0]        ent_act,
    input  logic              map_we,
    input  logic [TW-1:0]     map_line,
    input  logic [SEQ_W-1:0]  map_seq,
    input  logic [SEQ_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_start,
    output logic [CNT_W-1:0]  rd_count,
    output logic [DLY_W-1:0]  rd_delay,
    output logic [1:0]        rd_act,
    input  logic [TW-1:0]     map_rd_line,
    output logic [SEQ_W-1:0]  map_rd_seq
);
    logic [ADDR_W-1:0] start_q [DEPTH];
    logic [CNT_W-1:0]  count_q [DEPTH];
    logic [DLY_W-1:0]  delay_q [DEPTH];
    logic [1:0]        act_q   [DEPTH];
    logic [SEQ_W-1:0]  map_q   [N_TRIG];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[e] <= '0;
                count_q[e] <= '0;
                delay_q[e] <= '0;
                act_q[e]   <= 2'd3;
            end else if (ent_we && ent_idx == SEQ_W'(e)) begin
                start_q[e] <= ent_start;
                count_q[e] <= ent_count;
                delay_q[e] <= ent_delay;
                act_q[e]   <= ent_act;
            end
        end
    end

    for (genvar t = 0; t < N_TRIG; t++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[t] <= SEQ_W'(t);
            else if (map_we && map_line == TW'(t))
                map_q[t] <= map_seq;
        end
    end

    always_comb begin
        rd_start   = start_q[rd_idx];
        rd_count   = count_q[rd_idx];
        rd_delay   = delay_q[rd_idx];
        rd_act     = act_q[rd_idx];
        map_rd_seq = map_q[map_rd_line];
    end
endmodule

// File: rtl/spu_trig_pick.sv
module spu_trig_pick #(
    parameter int N_TRIG = 8,
    localparam int TW    = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic [N_TRIG-1:0] trig,
    output logic              any,
    output logic [TW-1:0]     line
);
    always_comb begin
        any  = |trig;
        line = '0;
        for (int i = N_TRIG - 1; i >= 0; i--) begin
            if (trig[i]) line = TW'(i);
        end
    end
endmodule

// File: rtl/spu_miss_ctr.sv
module spu_miss_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != {W{1'b1}})
            count <= count + 1'b1;
    end
endmodule

// File: rtl/spu_top.sv
module spu_top
    import spu_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int SEQ_W  = 4,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 10,
    parameter int DLY_W  = 16,
    parameter int MISS_W = 16,
    localparam int TW    = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_i,
    input  logic              abort_i,
    input  logic              map_we_i,
    input  logic [TW-1:0]     map_line_i,
    input  logic [SEQ_W-1:0]  map_seq_i,
    input  logic              tbl_we_i,
    input  logic [SEQ_W-1:0]  tbl_idx_i,
    input  logic [ADDR_W-1:0] tbl_start_i,
    input  logic [CNT_W-1:0]  tbl_count_i,
    input  logic [DLY_W-1:0]  tbl_delay_i,
    input  logic [1:0]        tbl_act_i,
    input  logic              disp_done_i,
    output logic [ADDR_W-1:0] disp_start_o,
    output logic [CNT_W-1:0]  disp_count_o,
    output logic              disp_run_o,
    output logic              busy_o,
    output logic [2:0]        state_o,
    output logic [SEQ_W-1:0]  cur_seq_o,
    output logic [MISS_W-1:0] missed_o
);
    spu_state_e        state_q, state_d;
    logic [SEQ_W-1:0]  seq_q, tgt_seq;
    logic [ADDR_W-1:0] start_q, rd_start;
    logic [CNT_W-1:0]  count_q, rd_count;
    logic [DLY_W-1:0]  dly_q, rd_delay;
    end_act_e          act_q;
    logic [1:0]        rd_act;
    logic              load;
    logic              trig_any;
    logic [TW-1:0]     trig_line;
    logic [SEQ_W-1:0]  map_seq;

    spu_trig_pick #(.N_TRIG(N_TRIG)) u_pick (
        .trig (trig_i),
        .any  (trig_any),
        .line (trig_line)
    );

    spu_seq_table #(
        .N_TRIG(N_TRIG), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .DLY_W(DLY_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .ent_we      (tbl_we_i),
        .ent_idx     (tbl_idx_i),
        .ent_start   (tbl_start_i),
        .ent_count   (tbl_count_i),
        .ent_delay   (tbl_delay_i),
        .ent_act     (tbl_act_i),
        .map_we      (map_we_i),
        .map_line    (map_line_i),
        .map_seq     (map_seq_i),
        .rd_idx      (tgt_seq),
        .rd_start    (rd_start),
        .rd_count    (rd_count),
        .rd_delay    (rd_delay),
        .rd_act      (rd_act),
        .map_rd_line (trig_line),
        .map_rd_seq  (map_seq)
    );

    spu_miss_ctr #(.W(MISS_W)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (busy_o && trig_any),
        .count (missed_o)
    );

    // Next-state and load selection
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        tgt_seq = seq_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_any) begin            // Launch
                    tgt_seq = map_seq;
                    load    = 1'b1;
                    state_d = ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (dly_q == '0) state_d = ST_RUN;   // Expire
            end
            ST_RUN: begin
                if (disp_done_i) begin
                    unique case (act_q)
                        ACT_RESTART: begin
                            load    = 1'b1;
                            state_d = ST_DELAY;
                        end
                        ACT_ADVANCE: begin
                            tgt_seq = seq_q + 1'b1;
                            load    = 1'b1;
                            state_d = ST_DELAY;
                        end
                        ACT_PARK:   state_d = ST_HOLD;
                        ACT_RETIRE: state_d = ST_IDLE;
                        default:    state_d = ST_IDLE;
                    endcase
                end
            end
            ST_HOLD: begin
                if (trig_any) begin            // Resume
                    tgt_seq = seq_q + 1'b1;
                    load    = 1'b1;
                    state_d = ST_DELAY;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort_i) begin                     // Abort
            state_d = ST_IDLE;
            load    = 1'b0;
        end
    end

    // State and captured entry registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seq_q   <= '0;
            start_q <= '0;
            count_q <= '0;
            dly_q   <= '0;
            act_q   <= ACT_RETIRE;
        end else begin
            state_q <= state_d;
            if (load) begin
                seq_q   <= tgt_seq;
                start_q <= rd_start;
                count_q <= rd_count;
                dly_q   <= rd_delay;
                act_q   <= end_act_e'(rd_act);
            end else if (state_q == ST_DELAY && dly_q != '0) begin
                dly_q <= dly_q - 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        disp_run_o   = (state_q == ST_RUN);
        busy_o       = (state_q == ST_DELAY) || (state_q == ST_RUN);
        state_o      = state_q;
        cur_seq_o    = seq_q;
        disp_start_o = start_q;
        disp_count_o = count_q;
    end
endmodule

// File: rtl/spu_checker.sv
module spu_checker #(
    parameter int N_TRIG = 8,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 10,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort_i,
    input logic [N_TRIG-1:0] trig_i,
    input logic              disp_done_i,
    input logic              disp_run_o,
    input logic              busy_o,
    input logic [ADDR_W-1:0] disp_start_o,
    input logic [CNT_W-1:0]  disp_count_o,
    input logic [MISS_W-1:0] missed_o
);
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !disp_run_o);

    assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_run_o && !disp_done_i && !abort_i |=> disp_run_o);

    assert_run_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_run_o && disp_done_i |=> !disp_run_o);

    assert_delay_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_run_o) |-> $past(busy_o));

    assert_payload_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        disp_run_o && !disp_done_i && !abort_i |=>
            $stable(disp_start_o) && $stable(disp_count_o));

    assert_miss_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && (|trig_i) && missed_o != {MISS_W{1'b1}} |=>
            missed_o == MISS_W'($past(missed_o) + 1'b1));

    assert_miss_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> missed_o == $past(missed_o));
endmodule

bind spu_top spu_checker #(
    .N_TRIG(N_TRIG), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MISS_W(MISS_W)
) u_spu_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort_i      (abort_i),
    .trig_i       (trig_i),
    .disp_done_i  (disp_done_i),
    .disp_run_o   (disp_run_o),
    .busy_o       (busy_o),
    .disp_start_o (disp_start_o),
    .disp_count_o (disp_count_o),
    .missed_o     (missed_o)
);

// File: tb/tb_spu_top.sv
module tb_spu_top;
    localparam int NT = 4, SW = 2, AW = 8, CW = 6, DW = 4, MW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] trig = '0;
    logic          abort = 1'b0;
    logic          map_we = 1'b0;
    logic [1:0]    map_line = '0;
    logic [SW-1:0] map_seq = '0;
    logic          tbl_we = 1'b0;
    logic [SW-1:0] tbl_idx = '0;
    logic [AW-1:0] tbl_start = '0;
    logic [CW-1:0] tbl_count = '0;
    logic [DW-1:0] tbl_delay = '0;
    logic [1:0]    tbl_act = '0;
    logic          done = 1'b0;
    logic [AW-1:0] d_start;
    logic [CW-1:0] d_count;
    logic          d_run, busy;
    logic [2:0]    st;
    logic [SW-1:0] cseq;
    logic [MW-1:0] missed;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spu_top #(.N_TRIG(NT), .SEQ_W(SW), .ADDR_W(AW), .CNT_W(CW),
              .DLY_W(DW), .MISS_W(MW)) dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .abort_i(abort),
        .map_we_i(map_we), .map_line_i(map_line), .map_seq_i(map_seq),
        .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_start_i(tbl_start),
        .tbl_count_i(tbl_count), .tbl_delay_i(tbl_delay), .tbl_act_i(tbl_act),
        .disp_done_i(done), .disp_start_o(d_start), .disp_count_o(d_count),
        .disp_run_o(d_run), .busy_o(busy), .state_o(st), .cur_seq_o(cseq),
        .missed_o(missed)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ent(input int idx, input int s, input int c,
                             input int d, input int a);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = SW'(idx); tbl_start = AW'(s);
        tbl_count = CW'(c); tbl_delay = DW'(d); tbl_act = 2'(a);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic pulse_trig(input logic [NT-1:0] p);
        trig = p;
        @(negedge clk);
        trig = '0;
    endtask

    task automatic pulse_done();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    // counts negedges until run is seen, starting at the current negedge
    task automatic wait_run(output int n);
        n = 0;
        while (!d_run && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int lowest(input int p);
        for (int i = 0; i < NT; i++) if (p[i]) return i;
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int n, m0, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 run", d_run, 0);
        check("R1 busy", busy, 0);
        check("R1 state", st, 0);
        check("R1 missed", missed, 0);

        // trigger map: line i -> sequence 3-i
        for (int i = 0; i < NT; i++) begin
            map_we = 1'b1; map_line = 2'(i); map_seq = SW'(3 - i);
            @(negedge clk);
        end
        map_we = 1'b0;
        for (int e = 0; e < 4; e++) write_ent(e, 16 * e + 3, e + 5, e, 3);

        // R2/R3/R4/R8 sweep over every nonzero trigger pattern
        for (int p = 1; p < 16; p++) begin
            s = 3 - lowest(p);
            pulse_trig(NT'(p));
            wait_run(n);
            check("R3 latency", n, s + 1);
            check("R2 start", d_start, 16 * s + 3);
            check("R2 count", d_count, s + 5);
            check("R2 seq", cseq, s);
            pulse_done();
            check("R4 run drop", d_run, 0);
            check("R8 idle", st, 0);
            check("R8 busy", busy, 0);
        end

        // R3 delay sweep on sequence 0 (line 3)
        for (int d = 0; d < 16; d++) begin
            write_ent(0, 3, 5, d, 3);
            pulse_trig(4'b1000);
            if (d > 0) check("R3 delay state", st, 1);
            wait_run(n);
            check("R3 delay", n, d + 1);
            if (d == 15) begin
                for (int k = 0; k < 5; k++) begin
                    @(negedge clk);
                    check("R4 hold", d_run, 1);
                end
            end
            pulse_done();
        end

        // R5 restart then R10 abort
        write_ent(1, 19, 6, 2, 0);
        pulse_trig(4'b0100);
        wait_run(n);
        check("R5 first", n, 3);
        pulse_done();
        check("R5 gap", d_run, 0);
        wait_run(n);
        check("R5 again", n, 3);
        check("R5 seq", cseq, 1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R10 run", d_run, 0);
        check("R10 state", st, 0);

        // R6 advance with wrap 3 -> 0
        write_ent(3, 51, 8, 1, 1);
        write_ent(0, 3, 5, 0, 3);
        pulse_trig(4'b0001);
        wait_run(n);
        check("R6 first start", d_start, 51);
        pulse_done();
        wait_run(n);
        check("R6 latency", n, 1);
        check("R6 wrap seq", cseq, 0);
        check("R6 start", d_start, 3);
        pulse_done();
        check("R6 idle", st, 0);

        // R7 park then resume on another line
        write_ent(2, 35, 7, 0, 2);
        write_ent(3, 51, 8, 0, 3);
        pulse_trig(4'b0010);
        wait_run(n);
        pulse_done();
        check("R7 hold state", st, 3);
        m0 = missed;
        pulse_trig(4'b0100);
        wait_run(n);
        check("R7 resume latency", n, 1);
        check("R7 resume seq", cseq, 3);
        check("R7 not missed", missed, m0);
        pulse_done();

        // R9 missed counting and saturation
        write_ent(0, 3, 5, 10, 3);
        pulse_trig(4'b1000);
        m0 = missed;
        trig = 4'b0110;
        repeat (3) @(negedge clk);
        trig = '0;
        check("R9 count", missed, m0 + 3);
        trig = 4'b0001;
        repeat (10) @(negedge clk);
        trig = '0;
        check("R9 saturate", missed, 7);
        wait_run(n);
        pulse_done();

        // R11 write during run does not disturb it
        write_ent(1, 19, 6, 0, 3);
        pulse_trig(4'b0100);
        wait_run(n);
        tbl_we = 1'b1; tbl_idx = 2'd1; tbl_start = 8'd99;
        tbl_count = 6'd6; tbl_delay = '0; tbl_act = 2'd3;
        @(negedge clk);
        tbl_we = 1'b0;
        check("R11 held start", d_start, 19);
        pulse_done();
        pulse_trig(4'b0100);
        wait_run(n);
        check("R11 new start", d_start, 99);
        pulse_done();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule